// File: doc/BRIEF.md
# Multiplexer and Accumulation Cycle Sequencer

This block paces the sampling of a four-channel metering front end. A 32768 Hz enable pulse (`tick_en`, one system clock wide per reference tick) advances a fixed frame of 13 ticks. Each frame, called a multiplexer cycle, lasts about 397 µs. The first four ticks of the frame each select one channel and emit a one-clock sample strobe. The remaining nine ticks are idle. At the end of every frame a sticky busy flag is raised so that firmware can collect per-frame status.

Frames are counted into accumulation cycles. An accumulation cycle holds a number of frames equal to the product of a coded factor and a cycle count. Both values come from one configuration byte. At the end of every accumulation cycle a sticky transfer flag reports that accumulated results are ready. The configuration byte is read only at an accumulation boundary, so the cycle in progress always finishes with the length it started with.

Top module: `mux_accum_seq`

## Requirements
- R1: A multiplexer cycle is exactly 13 `tick_en` pulses long. `busy_irq` becomes 1 on the clock edge that takes the 13th tick of each cycle.
- R2: On the first four ticks of a cycle, `chan_sel` takes the codes 0, 1, 2, 3 in that order: 0 = current B, 1 = voltage B, 2 = current A, 3 = voltage A.
- R3: `sample_stb` is 1 for one clock after each of the first four ticks of a cycle. It is 0 after ticks 5 to 13 and in every clock that does not follow a tick.
- R4: An accumulation cycle lasts factor × count multiplexer cycles. `xfer_irq` becomes 1 on the edge that ends the last of those cycles, which is the same edge that sets `busy_irq`.
- R5: The factor comes from `cfg_byte[7:6]`: code 0 gives 42, code 1 gives 50, code 2 gives 84 and code 3 gives 100.
- R6: The count comes from `cfg_byte[5:0]`. A count of 0 acts as a count of 1.
- R7: Each flag stays at 1 until its clear input is 1 for a clock. When a set and a clear land on the same edge, the flag is left at 1.
- R8: `cfg_byte` is sampled only when reset is released and at the end of each accumulation cycle. A change made mid-cycle has no effect on the length of the cycle in progress.
- R9: While `rst_n` is 0, all outputs are 0. After reset is released, the first tick starts a new multiplexer cycle and a new accumulation cycle.
- R10: In clocks without `tick_en`, `chan_sel` holds its value and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock pulse at each 32768 Hz reference tick |
| cfg_byte | input | 8 | Bits 7:6 hold the factor code; bits 5:0 hold the cycle count |
| chan_sel | output | 2 | Channel selected by the most recent sampling tick |
| sample_stb | output | 1 | One-clock strobe at the start of each channel slot |
| busy_irq | output | 1 | Sticky end-of-multiplexer-cycle flag |
| busy_clr | input | 1 | Clears `busy_irq` |
| xfer_irq | output | 1 | Sticky end-of-accumulation-cycle flag |
| xfer_clr | input | 1 | Clears `xfer_irq` |

## Verification
A wrong slot count appears within one frame. It shows as a strobe on a tick that should be idle, a channel code out of order, or `busy_irq` rising on the wrong tick. A wrong frame counter or wrong latched target stays hidden until the end of an accumulation cycle. It then shows as `xfer_irq` rising one or more frames early or late, which can take up to 6300 frames. For this reason the bench uses short cycle counts and changes `cfg_byte` in the middle of a cycle. That exposes a target that was latched at the wrong time at the very next boundary.

// File: rtl/mas_pkg.sv
package mas_pkg;

   localparam int unsigned FACTOR_W = 7;

   // channel codes in slot order
   typedef enum logic [1:0] {
      CH_IB = 2'd0,
      CH_VB = 2'd1,
      CH_IA = 2'd2,
      CH_VA = 2'd3
   } chan_e;

   function automatic logic [FACTOR_W-1:0] mas_factor(input logic [1:0] code);
      logic [FACTOR_W-1:0] f;
      case (code)
         2'd0:    f = 7'd42;
         2'd1:    f = 7'd50;
         2'd2:    f = 7'd84;
         default: f = 7'd100;
      endcase
      return f;
   endfunction

endpackage

// File: rtl/mas_frame_ctr.sv
module mas_frame_ctr #(
   parameter int unsigned TICKS  = 13,
   parameter int unsigned NCH    = 4,
   parameter int unsigned SLOT_W = 4,
   parameter int unsigned CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   output logic [CH_W-1:0]   chan_sel,
   output logic              sample_stb,
   output logic              mux_end
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TICKS - 1);
   localparam logic [SLOT_W-1:0] CH_SLOTS  = SLOT_W'(NCH);

   logic [SLOT_W-1:0] slot_q;

   assign mux_end = tick_en && (slot_q == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q     <= '0;
         chan_sel   <= '0;
         sample_stb <= 1'b0;
      end else begin
         sample_stb <= 1'b0;
         if (tick_en) begin
            if (slot_q < CH_SLOTS) begin
               sample_stb <= 1'b1;
               chan_sel   <= slot_q[CH_W-1:0];
            end
            if (slot_q == LAST_SLOT) slot_q <= '0;
            else                     slot_q <= slot_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/mas_accum_ctr.sv
module mas_accum_ctr
   import mas_pkg::*;
#(
   parameter int unsigned CODE_W = 2,
   parameter int unsigned CNT_W  = 6,
   parameter int unsigned TGT_W  = FACTOR_W + CNT_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mux_end,
   input  logic [CODE_W+CNT_W-1:0] cfg,
   output logic                    acc_end,
   output logic [TGT_W-1:0]        tgt_q
);

   logic [TGT_W-1:0] cnt_q;
   logic [TGT_W-1:0] tgt_new;
   logic [CNT_W-1:0] cyc_cnt;

   always_comb begin
      cyc_cnt = cfg[CNT_W-1:0];
      if (cyc_cnt == '0) cyc_cnt = CNT_W'(1);
      tgt_new = TGT_W'(mas_factor(cfg[CODE_W+CNT_W-1 -: 2])) * TGT_W'(cyc_cnt);
   end

   assign acc_end = mux_end && (tgt_q != '0) && (cnt_q == tgt_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= '0;
      end else begin
         if (tgt_q == '0) tgt_q <= tgt_new;
         if (mux_end) begin
            if (acc_end) begin
               cnt_q <= '0;
               tgt_q <= tgt_new;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mas_sticky_flag.sv
module mas_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end

endmodule

// File: rtl/mux_accum_seq.sv
module mux_accum_seq
   import mas_pkg::*;
#(
   parameter int unsigned TICKS_PER_MUX = 13,
   parameter int unsigned NUM_CHAN      = 4,
   parameter int unsigned CODE_W        = 2,
   parameter int unsigned CNT_W         = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_en,
   input  logic [CODE_W+CNT_W-1:0] cfg_byte,
   output logic [1:0]              chan_sel,
   output logic                    sample_stb,
   output logic                    busy_irq,
   input  logic                    busy_clr,
   output logic                    xfer_irq,
   input  logic                    xfer_clr
);

   localparam int unsigned SLOT_W = $clog2(TICKS_PER_MUX);
   localparam int unsigned CH_W   = $clog2(NUM_CHAN);
   localparam int unsigned TGT_W  = FACTOR_W + CNT_W;
   localparam int unsigned NFLAG  = 2;

   if (NUM_CHAN > TICKS_PER_MUX) begin : g_bad_slots
      $error("mux_accum_seq: more channels than ticks per frame");
   end
   if (CH_W != 2) begin : g_bad_chan
      $error("mux_accum_seq: channel select port is two bits wide");
   end
   if (CODE_W != 2) begin : g_bad_code
      $error("mux_accum_seq: factor code must be two bits");
   end

   logic             mux_end;
   logic             acc_end;
   logic [TGT_W-1:0] acc_tgt;
   logic [NFLAG-1:0] flag_set;
   logic [NFLAG-1:0] flag_clr;
   logic [NFLAG-1:0] flag_q;

   mas_frame_ctr #(
      .TICKS (TICKS_PER_MUX),
      .NCH   (NUM_CHAN),
      .SLOT_W(SLOT_W),
      .CH_W  (CH_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .chan_sel  (chan_sel),
      .sample_stb(sample_stb),
      .mux_end   (mux_end)
   );

   mas_accum_ctr #(
      .CODE_W(CODE_W),
      .CNT_W (CNT_W),
      .TGT_W (TGT_W)
   ) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .mux_end(mux_end),
      .cfg    (cfg_byte),
      .acc_end(acc_end),
      .tgt_q  (acc_tgt)
   );

   assign flag_set = {acc_end, mux_end};
   assign flag_clr = {xfer_clr, busy_clr};

   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      mas_sticky_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (flag_set[g]),
         .clr_i (flag_clr[g]),
         .flag_o(flag_q[g])
      );
   end

   assign busy_irq = flag_q[0];
   assign xfer_irq = flag_q[1];

endmodule

// File: rtl/mas_seq_checker.sv
module mas_seq_checker #(
   parameter int unsigned TGT_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_en,
   input logic [1:0]       chan_sel,
   input logic             sample_stb,
   input logic             busy_irq,
   input logic             busy_clr,
   input logic             xfer_irq,
   input logic             xfer_clr,
   input logic [TGT_W-1:0] tgt_q,
   input logic             acc_end
);

   AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> $past(tick_en)); // R3

   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(chan_sel)); // R10

   AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_irq && !tick_en) |=> !busy_irq); // R10

   AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_irq && !busy_clr) |=> busy_irq); // R7

   AST_XFER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_irq && !xfer_clr) |=> xfer_irq); // R7

   AST_XFER_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_irq) |-> busy_irq); // R4

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q != '0 && !acc_end) |=> $stable(tgt_q)); // R8

endmodule

bind mux_accum_seq mas_seq_checker #(.TGT_W(TGT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .chan_sel  (chan_sel),
   .sample_stb(sample_stb),
   .busy_irq  (busy_irq),
   .busy_clr  (busy_clr),
   .xfer_irq  (xfer_irq),
   .xfer_clr  (xfer_clr),
   .tgt_q     (acc_tgt),
   .acc_end   (acc_end)
);

// File: tb/mux_accum_seq_bench.sv
module mux_accum_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [7:0] cfg_byte = 8'h01;
   logic [1:0] chan_sel;
   logic       sample_stb;
   logic       busy_irq;
   logic       busy_clr = 1'b0;
   logic       xfer_irq;
   logic       xfer_clr = 1'b0;

   int    total = 0;
   int    bad = 0;
   int    pos = 0;
   int    done = 0;
   int    tgt = 0;
   int    xfers = 0;
   int    cycles = 0;
   string xtag = "R4";

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_accum_seq u_mux_accum_seq (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_byte(cfg_byte),
      .chan_sel(chan_sel), .sample_stb(sample_stb),
      .busy_irq(busy_irq), .busy_clr(busy_clr),
      .xfer_irq(xfer_irq), .xfer_clr(xfer_clr)
   );

   function automatic int calc_len(input logic [7:0] c);
      int f, n;
      case (c[7:6])
         2'd0: f = 42;
         2'd1: f = 50;
         2'd2: f = 84;
         default: f = 100;
      endcase
      n = (c[5:0] == 0) ? 1 : int'(c[5:0]);
      return f * n;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!sample_stb && !busy_irq && !xfer_irq && chan_sel == 2'd0, "R9 reset outputs",
          {sample_stb, busy_irq, xfer_irq, chan_sel}, 0);
      rst_n = 1'b1;
      pos = 0; done = 0; tgt = calc_len(cfg_byte);
   endtask

   task automatic tick_once(input bit collide);
      bit e_stb, e_busy, e_xfer;
      int e_ch;
      @(negedge clk);
      chk(!sample_stb, "R3 strobe low between ticks", sample_stb, 0);
      tick_en = 1'b1; busy_clr = collide; xfer_clr = collide;
      @(negedge clk);
      tick_en = 1'b0; busy_clr = 1'b0; xfer_clr = 1'b0;
      e_stb = (pos < 4); e_ch = pos; e_busy = (pos == 12); e_xfer = 1'b0;
      if (pos == 12) begin
         done++;
         if (done == tgt) begin
            e_xfer = 1'b1; done = 0; tgt = calc_len(cfg_byte); xfers++;
         end
      end
      pos = (pos == 12) ? 0 : pos + 1;
      if (e_stb) begin
         chk(sample_stb == 1'b1, "R3 strobe on channel slot", sample_stb, 1);
         chk(int'(chan_sel) == e_ch, "R2 channel order", chan_sel, e_ch);
      end else begin
         chk(sample_stb == 1'b0, "R3 idle slot strobe", sample_stb, 0);
      end
      chk(busy_irq == e_busy, collide ? "R7 busy set wins" : "R1 busy at frame end",
          busy_irq, e_busy);
      chk(xfer_irq == e_xfer, collide ? "R7 xfer set wins" : xtag, xfer_irq, e_xfer);
      busy_clr = e_busy; xfer_clr = e_xfer;
   endtask

   task automatic run_ticks(input int n);
      for (int i = 0; i < n; i++) tick_once(1'b0);
   endtask

   task automatic run_to_xfer(input bit rnd_collide);
      int start = xfers;
      while (xfers == start) tick_once(rnd_collide && pos == 12 && ($urandom_range(0, 3) == 0));
   endtask

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      cfg_byte = 8'h01;
      do_reset();
      // R10: no ticks, nothing moves
      repeat (20) @(negedge clk);
      chk(!busy_irq && !xfer_irq && !sample_stb && chan_sel == 2'd0, "R10 idle without ticks",
          {busy_irq, xfer_irq, sample_stb}, 0);
      // first accumulation: 42 frames; change cfg midway, R8
      run_ticks(5 * 13);
      cfg_byte = 8'h00;
      xtag = "R8 old length kept";
      run_to_xfer(1'b0);
      chk(tgt == 42, "R6 zero count target", tgt, 42);
      xtag = "R6 zero count as one";
      run_ticks(3 * 13 + 12);
      tick_once(1'b1); // R7 collision on a frame end
      cfg_byte = 8'h42;
      run_to_xfer(1'b0);
      xtag = "R5 factor 50";
      run_to_xfer(1'b0);
      // reset mid-run restarts the frame, R9
      run_ticks(7);
      do_reset();
      xtag = "R4 R9 restart";
      run_ticks(13);
      chk(done == 1, "R9 restart count", done, 1);
      // random configurations, R4 and R5
      for (int k = 0; k < 4; k++) begin
         xtag = "R4 R5 random length";
         run_ticks($urandom_range(0, 12 * 13));
         cfg_byte = {2'($urandom_range(0, 3)), 6'($urandom_range(0, 3))};
         run_to_xfer(1'b1);
         run_to_xfer(1'b1);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule